// File: doc/BRIEF.md
# Linear CCD Line Readout Timing Generator

This block produces the digital drive pattern for one line of a four-register linear CCD image sensor. It runs from a fast system clock and repeats a line cycle without pause. Each cycle opens with a transfer window, in which the photosite charge is moved into the shift registers. Readout of the line follows. After it come a few cleaning pixel periods, during which the register clocks keep running. The transfer window then repeats.

Within each pixel period the block drives the complementary main transport phases, the end-stage clock and the reset strobe. It also gives one-cycle clamp and sample strobes for a correlated double sampling front end. With the strobes it gives a 3-bit tag that says what kind of element is on the output. An exposure gate output shortens integration by keeping the photosites drained for the start of the readout.

Three settings are taken from input pins: the pixel period in system-clock cycles, the choice of two or four outputs, and the integration length in pixel periods. They are copied into shadow registers only at a line boundary. Analog levels, clock drivers and the converter are outside this block.

Top module: `ccd_line_timing`

## Requirements
- R1: While reset is held, o_xfer, o_l2, o_ls, o_rst, o_clamp, o_sample and o_agate are 0, o_l1 is 1 and o_tag is 5.
- R2: o_xfer pulses once per line and stays high for exactly XFER_CYC cycles. From GUARD_CYC cycles before it rises until GUARD_CYC cycles after it falls, o_l1 stays 1 and o_l2, o_ls and o_rst stay 0. o_l1 falls GUARD_CYC + floor(Tp/2) cycles after o_xfer falls, where Tp is the pixel period.
- R3: o_l1 and o_l2 are never equal. During readout, o_l1 is high for the first floor(Tp/2) cycles of each pixel period and o_l2 for the rest.
- R4: In each pixel period o_rst is high for the first RST_CYC cycles. o_clamp is high for one cycle at offset RST_CYC+GAP_CYC. o_sample is high for one cycle at offset floor(Tp/2)+RST_CYC+GAP_CYC. o_ls rises at offset floor(Tp/2). No two of o_rst, o_clamp and o_sample are high together.
- R5: A requested pixel period below 2*(RST_CYC+GAP_CYC)+2 cycles is raised to that minimum.
- R6: In four-output mode (cfg_two_out=0) a line reads SEG pixel periods, and in two-output mode (cfg_two_out=1) it reads 2*SEG. SEG is the sum of the five element counts. CLEAN_N cleaning periods follow, with every pixel strobe still running. The time from one o_xfer rise to the next is 2*GUARD_CYC + XFER_CYC + (pixels + CLEAN_N)*Tp.
- R7: o_tag gives the element kind: 0 prescan, 1 dark reference, 2 isolation, 3 non-useful, 4 useful, 5 overscan/cleaning or transfer. Each register segment runs PRE_N prescan, DARK_N dark, ISO_N isolation, NU_N non-useful and USE_N useful elements, in that order. In two-output mode the same segment order is read twice, then the cleaning periods follow.
- R8: With L the total number of pixel periods in the line (readout plus cleaning) and E the integration length, o_agate is high for the first L-E pixel periods after the transfer window and low for the rest of the line.
- R9: If E is at least L, o_agate stays low. The number of gated pixel periods is capped at PRE_N+DARK_N+ISO_N+NU_N, so o_agate is never high while o_tag is 4.
- R10: Changes to cfg_tp, cfg_two_out and cfg_exp take effect only at the cycle in which a transfer window begins. The line in progress keeps its settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_tp | input | TP_W | Requested pixel period in clock cycles |
| cfg_two_out | input | 1 | 1 = two-output line, 0 = four-output line |
| cfg_exp | input | EXP_W | Integration length in pixel periods |
| o_xfer | output | 1 | Photosite-to-register transfer pulse |
| o_l1 | output | 1 | Main transport phase 1 |
| o_l2 | output | 1 | Main transport phase 2 (complement of o_l1) |
| o_ls | output | 1 | End-stage transport clock |
| o_rst | output | 1 | Output node reset strobe |
| o_clamp | output | 1 | Reference-level strobe, one cycle per pixel |
| o_sample | output | 1 | Signal-level strobe, one cycle per pixel |
| o_agate | output | 1 | Exposure-control gate |
| o_tag | output | 3 | Element kind of the current pixel period |

## Verification
The embedded properties assume only that reset is applied first and that the parameters are consistent, that is, the raised minimum pixel period fits in TP_W bits. The configuration pins may change in any cycle, because the properties look only at the shadowed values and the registered outputs. The stimulus changes the configuration on the falling clock edge right after a transfer pulse is seen. This leaves the line already in progress on its latched settings. Each measured line therefore has an expected length, tag order and gate width that can be worked out in advance, and the boundary test deliberately measures that in-progress line to show that the old setting still holds.

// File: rtl/ccd_tg_pkg.sv
// Shared types for the linear CCD line timing generator.
package ccd_tg_pkg;
    // Element kind reported alongside the pixel strobes.
    typedef enum logic [2:0] {
        TAG_PRESCAN = 3'd0,
        TAG_DARK    = 3'd1,
        TAG_ISO     = 3'd2,
        TAG_NONUSE  = 3'd3,
        TAG_USEFUL  = 3'd4,
        TAG_OVER    = 3'd5
    } elem_tag_e;
endpackage

// File: rtl/ccd_tg_cfg.sv
// Configuration shadow: copies the pin settings only at a line boundary,
// raising the pixel period to its floor and capping the gated pixel count.
// Assumes TP_MIN fits in TP_W bits.
module ccd_tg_cfg #(
    parameter int TP_W    = 8,
    parameter int EXP_W   = 14,
    parameter int IDX_W   = 13,
    parameter int SEG_N   = 3043,
    parameter int CLEAN_N = 8,
    parameter int U0_N    = 43,
    parameter int TP_MIN  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TP_W-1:0]  cfg_tp,
    input  logic             cfg_two_out,
    input  logic [EXP_W-1:0] cfg_exp,
    output logic [TP_W-1:0]  tp_q,
    output logic [IDX_W-1:0] npix_q,
    output logic [IDX_W-1:0] last_q,
    output logic [IDX_W-1:0] fall_q
);
    localparam int CW = ((EXP_W > IDX_W) ? EXP_W : IDX_W) + 1;

    logic [TP_W-1:0]  tp_n;
    logic [IDX_W-1:0] npix_n, last_n, fall_n;
    logic [CW-1:0]    tot, exp_x, diff;

    // Derive the next shadow values from the pins.
    always_comb begin
        tp_n   = (cfg_tp < TP_W'(TP_MIN)) ? TP_W'(TP_MIN) : cfg_tp;
        npix_n = cfg_two_out ? IDX_W'(2 * SEG_N) : IDX_W'(SEG_N);
        last_n = npix_n + IDX_W'(CLEAN_N) - IDX_W'(1);
        tot    = CW'(npix_n) + CW'(CLEAN_N);
        exp_x  = CW'(cfg_exp);
        diff   = '0;
        if (exp_x >= tot) begin
            fall_n = '0;
        end else begin
            diff   = tot - exp_x;
            fall_n = (diff > CW'(U0_N)) ? IDX_W'(U0_N) : IDX_W'(diff);
        end
    end

    // Shadow registers, loaded in reset and at each line boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            tp_q   <= tp_n;
            npix_q <= npix_n;
            last_q <= last_n;
            fall_q <= fall_n;
        end
    end

    // R10: settings hold between line boundaries
    a_r10_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(tp_q) && $stable(npix_q) && $stable(fall_q)));
endmodule

// File: rtl/ccd_tg_seq.sv
// Line sequencer: transfer window counter, pixel phase counter and pixel
// index. Flags the last cycle of a line so the shadow can reload.
// Assumes tp >= 2 and last_idx only changes together with line_end.
module ccd_tg_seq #(
    parameter int TP_W      = 8,
    parameter int IDX_W     = 13,
    parameter int GUARD_CYC = 2,
    parameter int XFER_CYC  = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TP_W-1:0]  tp,
    input  logic [IDX_W-1:0] last_idx,
    output logic             in_xfer,
    output logic [TP_W-1:0]  ph,
    output logic [IDX_W-1:0] idx,
    output logic             p_on,
    output logic             line_end
);
    localparam int XTOT = 2 * GUARD_CYC + XFER_CYC;
    localparam int XW   = $clog2(XTOT + 1);

    logic [XW-1:0] xcnt;
    logic          ph_last;

    // Decode end of pixel period and end of line.
    always_comb begin
        ph_last  = (ph == tp - TP_W'(1));
        line_end = !in_xfer && ph_last && (idx == last_idx);
        p_on     = in_xfer && (xcnt >= XW'(GUARD_CYC)) && (xcnt < XW'(GUARD_CYC + XFER_CYC));
    end

    // Advance transfer window, then pixel phase and index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_xfer <= 1'b1;
            xcnt    <= '0;
            ph      <= '0;
            idx     <= '0;
        end else if (in_xfer) begin
            if (xcnt == XW'(XTOT - 1)) begin
                in_xfer <= 1'b0;
                xcnt    <= '0;
                ph      <= '0;
                idx     <= '0;
            end else begin
                xcnt <= xcnt + XW'(1);
            end
        end else if (ph_last) begin
            ph <= '0;
            if (idx == last_idx) begin
                in_xfer <= 1'b1;
                xcnt    <= '0;
            end else begin
                idx <= idx + IDX_W'(1);
            end
        end else begin
            ph <= ph + TP_W'(1);
        end
    end

    // R5: phase stays inside the latched pixel period
    a_r5_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
        !in_xfer |-> (ph < tp));
    // R6: pixel index never passes the line end
    a_r6_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
        !in_xfer |-> (idx <= last_idx));
endmodule

// File: rtl/ccd_tg_pix.sv
// Per-pixel strobe decode from the phase counter: transport phases,
// end-stage clock, reset, clamp and sample. Outside readout the phases
// are frozen with phase 1 high. Assumes tp >= 2*(RST+GAP)+2.
module ccd_tg_pix #(
    parameter int TP_W    = 8,
    parameter int RST_CYC = 2,
    parameter int GAP_CYC = 3
) (
    input  logic            active,
    input  logic [TP_W-1:0] tp,
    input  logic [TP_W-1:0] ph,
    output logic            l1,
    output logic            l2,
    output logic            ls,
    output logic            rs,
    output logic            clamp,
    output logic            smp
);
    localparam logic [TP_W-1:0] RW = TP_W'(RST_CYC);
    localparam logic [TP_W-1:0] CL = TP_W'(RST_CYC + GAP_CYC);

    logic [TP_W-1:0] half;

    // Decode strobes for the current phase.
    always_comb begin
        half = tp >> 1;
        if (active) begin
            l1    = (ph < half);
            l2    = !(ph < half);
            ls    = (ph >= half);
            rs    = (ph < RW);
            clamp = (ph == CL);
            smp   = (ph == half + CL);
        end else begin
            l1    = 1'b1;
            l2    = 1'b0;
            ls    = 1'b0;
            rs    = 1'b0;
            clamp = 1'b0;
            smp   = 1'b0;
        end
    end
endmodule

// File: rtl/ccd_tg_tag.sv
// Element tag and exposure gate decode from the pixel index.
// Two-output lines repeat the segment order once more.
module ccd_tg_tag
    import ccd_tg_pkg::*;
#(
    parameter int IDX_W  = 13,
    parameter int PRE_N  = 30,
    parameter int DARK_N = 6,
    parameter int ISO_N  = 4,
    parameter int NU_N   = 3,
    parameter int USE_N  = 3000
) (
    input  logic             active,
    input  logic [IDX_W-1:0] idx,
    input  logic [IDX_W-1:0] npix,
    input  logic [IDX_W-1:0] fall,
    output elem_tag_e        tag,
    output logic             agate
);
    localparam int SEG = PRE_N + DARK_N + ISO_N + NU_N + USE_N;

    logic [IDX_W-1:0] j;

    // Fold the index into one segment and classify it.
    always_comb begin
        j = (idx >= IDX_W'(SEG)) ? (idx - IDX_W'(SEG)) : idx;
        if (!active || idx >= npix)                     tag = TAG_OVER;
        else if (j < IDX_W'(PRE_N))                     tag = TAG_PRESCAN;
        else if (j < IDX_W'(PRE_N + DARK_N))            tag = TAG_DARK;
        else if (j < IDX_W'(PRE_N + DARK_N + ISO_N))    tag = TAG_ISO;
        else if (j < IDX_W'(PRE_N + DARK_N + ISO_N + NU_N)) tag = TAG_NONUSE;
        else                                            tag = TAG_USEFUL;
        agate = active && (idx < fall);
    end
endmodule

// File: rtl/ccd_line_timing.sv
// Top of the linear CCD line timing generator. Ties the shadow, sequencer
// and decoders together and registers every output once, so all outputs
// share one cycle of latency. Assumes the raised minimum period fits TP_W.
module ccd_line_timing
    import ccd_tg_pkg::*;
#(
    parameter int TP_W      = 8,
    parameter int EXP_W     = 14,
    parameter int PRE_N     = 30,
    parameter int DARK_N    = 6,
    parameter int ISO_N     = 4,
    parameter int NU_N      = 3,
    parameter int USE_N     = 3000,
    parameter int CLEAN_N   = 8,
    parameter int XFER_CYC  = 200,
    parameter int GUARD_CYC = 2,
    parameter int RST_CYC   = 2,
    parameter int GAP_CYC   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TP_W-1:0]  cfg_tp,
    input  logic             cfg_two_out,
    input  logic [EXP_W-1:0] cfg_exp,
    output logic             o_xfer,
    output logic             o_l1,
    output logic             o_l2,
    output logic             o_ls,
    output logic             o_rst,
    output logic             o_clamp,
    output logic             o_sample,
    output logic             o_agate,
    output logic [2:0]       o_tag
);
    localparam int SEG_N  = PRE_N + DARK_N + ISO_N + NU_N + USE_N;
    localparam int U0_N   = PRE_N + DARK_N + ISO_N + NU_N;
    localparam int IDX_W  = $clog2(2 * SEG_N + CLEAN_N + 1);
    localparam int TP_MIN = 2 * (RST_CYC + GAP_CYC) + 2;

    logic [TP_W-1:0]  tp_q, ph;
    logic [IDX_W-1:0] npix_q, last_q, fall_q, idx;
    logic             in_xfer, p_on, line_end;
    logic             l1, l2, ls, rs, clamp, smp, agate;
    elem_tag_e        tag;

    ccd_tg_cfg #(
        .TP_W(TP_W), .EXP_W(EXP_W), .IDX_W(IDX_W), .SEG_N(SEG_N),
        .CLEAN_N(CLEAN_N), .U0_N(U0_N), .TP_MIN(TP_MIN)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(line_end),
        .cfg_tp(cfg_tp), .cfg_two_out(cfg_two_out), .cfg_exp(cfg_exp),
        .tp_q(tp_q), .npix_q(npix_q), .last_q(last_q), .fall_q(fall_q)
    );

    ccd_tg_seq #(
        .TP_W(TP_W), .IDX_W(IDX_W), .GUARD_CYC(GUARD_CYC), .XFER_CYC(XFER_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .tp(tp_q), .last_idx(last_q),
        .in_xfer(in_xfer), .ph(ph), .idx(idx), .p_on(p_on), .line_end(line_end)
    );

    ccd_tg_pix #(
        .TP_W(TP_W), .RST_CYC(RST_CYC), .GAP_CYC(GAP_CYC)
    ) u_pix (
        .active(!in_xfer), .tp(tp_q), .ph(ph),
        .l1(l1), .l2(l2), .ls(ls), .rs(rs), .clamp(clamp), .smp(smp)
    );

    ccd_tg_tag #(
        .IDX_W(IDX_W), .PRE_N(PRE_N), .DARK_N(DARK_N), .ISO_N(ISO_N),
        .NU_N(NU_N), .USE_N(USE_N)
    ) u_tag (
        .active(!in_xfer), .idx(idx), .npix(npix_q), .fall(fall_q),
        .tag(tag), .agate(agate)
    );

    // Output register stage with reset levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_xfer   <= 1'b0;
            o_l1     <= 1'b1;
            o_l2     <= 1'b0;
            o_ls     <= 1'b0;
            o_rst    <= 1'b0;
            o_clamp  <= 1'b0;
            o_sample <= 1'b0;
            o_agate  <= 1'b0;
            o_tag    <= TAG_OVER;
        end else begin
            o_xfer   <= p_on;
            o_l1     <= l1;
            o_l2     <= l2;
            o_ls     <= ls;
            o_rst    <= rs;
            o_clamp  <= clamp;
            o_sample <= smp;
            o_agate  <= agate;
            o_tag    <= tag;
        end
    end

    // R3: transport phases are complementary
    a_r3_phase_complement: assert property (@(posedge clk) disable iff (!rst_n)
        o_l1 != o_l2);
    // R2: transport and reset clocks frozen while the transfer pulse is high
    a_r2_xfer_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        o_xfer |-> (o_l1 && !o_l2 && !o_ls && !o_rst));
    // R2: guard cycle before the pulse also frozen
    a_r2_xfer_guard: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(o_xfer) |-> ($past(o_l1) && !$past(o_rst)));
    // R4: reset, clamp and sample never overlap
    a_r4_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({o_rst, o_clamp, o_sample}) <= 1);
    // R9: exposure gate never open over a useful pixel
    a_r9_gate_outside: assert property (@(posedge clk) disable iff (!rst_n)
        o_agate |-> (o_tag != 3'(TAG_USEFUL)));
endmodule

// File: tb/tb_ccd_line_timing.sv
module tb_ccd_line_timing;
    localparam int TPW = 8, EXPW = 14;
    localparam int PRE = 3, DARK = 2, ISO = 1, NU = 1, USE = 5, CLEAN = 3;
    localparam int XFER = 6, GUARD = 2, RSTC = 2, GAP = 3;
    localparam int SEG = PRE + DARK + ISO + NU + USE;
    localparam int U0 = PRE + DARK + ISO + NU;
    localparam int XTOT = 2 * GUARD + XFER;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [TPW-1:0] cfg_tp = 8'd12;
    logic cfg_two_out = 1'b0;
    logic [EXPW-1:0] cfg_exp = 14'd100;
    logic o_xfer, o_l1, o_l2, o_ls, o_rst, o_clamp, o_sample, o_agate;
    logic [2:0] o_tag;

    int n_chk = 0, n_bad = 0;
    int ln_cyc, ln_pix, ln_pw, ln_ahi, ln_ug, ln_lc;
    int ln_tag [0:63];

    ccd_line_timing #(
        .TP_W(TPW), .EXP_W(EXPW), .PRE_N(PRE), .DARK_N(DARK), .ISO_N(ISO),
        .NU_N(NU), .USE_N(USE), .CLEAN_N(CLEAN), .XFER_CYC(XFER),
        .GUARD_CYC(GUARD), .RST_CYC(RSTC), .GAP_CYC(GAP)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cfg_tp(cfg_tp), .cfg_two_out(cfg_two_out),
        .cfg_exp(cfg_exp), .o_xfer(o_xfer), .o_l1(o_l1), .o_l2(o_l2),
        .o_ls(o_ls), .o_rst(o_rst), .o_clamp(o_clamp), .o_sample(o_sample),
        .o_agate(o_agate), .o_tag(o_tag)
    );

    always #5 clk = ~clk;

    task automatic check_eq(string req, string what, int act, int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic sync_rise();
        do @(negedge clk); while (o_xfer);
        do @(negedge clk); while (!o_xfer);
    endtask

    // Tag expected from the R7 ordering.
    function automatic int exp_tag(int pix, bit two);
        int npix = two ? 2 * SEG : SEG;
        int j;
        if (pix >= npix) return 5;
        j = (pix >= SEG) ? pix - SEG : pix;
        if (j < PRE) return 0;
        if (j < PRE + DARK) return 1;
        if (j < PRE + DARK + ISO) return 2;
        if (j < U0) return 3;
        return 4;
    endfunction

    task automatic accum();
        if (o_xfer) ln_pw++;
        if (o_clamp) begin
            if (ln_pix < 64) ln_tag[ln_pix] = int'(o_tag);
            ln_pix++;
        end
        if (o_agate) ln_ahi++;
        if (o_agate && o_tag == 3'd4) ln_ug++;
        if (o_l1 == o_l2) ln_lc++;
    endtask

    task automatic scan_line();
        logic pp;
        sync_rise();
        ln_cyc = 0; ln_pix = 0; ln_pw = 0; ln_ahi = 0; ln_ug = 0; ln_lc = 0;
        accum();
        pp = 1'b1;
        forever begin
            @(negedge clk);
            ln_cyc++;
            if (o_xfer && !pp) break;
            pp = o_xfer;
            accum();
        end
    endtask

    // Full line check against R2, R3, R6, R7, R8, R9.
    task automatic check_line(string nm, bit two, int tp, int expo);
        int tot = (two ? 2 * SEG : SEG) + CLEAN;
        int f = (expo >= tot) ? 0 : ((tot - expo > U0) ? U0 : tot - expo);
        int tbad = 0;
        scan_line();
        check_eq("R6", {nm, " line cycles"}, ln_cyc, XTOT + tot * tp);
        check_eq("R6", {nm, " pixel periods"}, ln_pix, tot);
        check_eq("R2", {nm, " transfer width"}, ln_pw, XFER);
        check_eq("R3", {nm, " equal phase cycles"}, ln_lc, 0);
        for (int k = 0; k < tot && k < 64; k++)
            if (ln_tag[k] != exp_tag(k, two)) tbad++;
        check_eq("R7", {nm, " tag mismatches"}, tbad, 0);
        check_eq("R8", {nm, " gate high cycles"}, ln_ahi, f * tp);
        check_eq("R9", {nm, " gate over useful"}, ln_ug, 0);
    endtask

    // Offsets of strobes within one pixel period (R3, R4).
    task automatic t_pixel(string nm, int tp);
        int rw = 0, cl = -1, sa = -1, l1w = 0, lsr = -1;
        sync_rise();
        do @(negedge clk); while (o_xfer);
        do @(negedge clk); while (!o_rst);
        for (int k = 0; k < tp; k++) begin
            if (k > 0) @(negedge clk);
            if (o_rst) rw++;
            if (o_clamp) cl = k;
            if (o_sample) sa = k;
            if (o_l1) l1w++;
            if (o_ls && lsr < 0) lsr = k;
        end
        check_eq("R4", {nm, " reset width"}, rw, RSTC);
        check_eq("R4", {nm, " clamp offset"}, cl, RSTC + GAP);
        check_eq("R4", {nm, " sample offset"}, sa, tp / 2 + RSTC + GAP);
        check_eq("R4", {nm, " end-stage rise"}, lsr, tp / 2);
        check_eq("R3", {nm, " phase1 width"}, l1w, tp / 2);
    endtask

    task automatic t_reset();
        @(negedge clk); @(negedge clk);
        check_eq("R1", "xfer in reset", int'(o_xfer), 0);
        check_eq("R1", "l1 in reset", int'(o_l1), 1);
        check_eq("R1", "l2/ls/rst in reset", int'({o_l2, o_ls, o_rst}), 0);
        check_eq("R1", "clamp/sample/gate in reset", int'({o_clamp, o_sample, o_agate}), 0);
        check_eq("R1", "tag in reset", int'(o_tag), 5);
    endtask

    task automatic t_guard();
        int since = 0, n = 0;
        logic pl1, pp;
        sync_rise();
        do @(negedge clk); while (o_xfer);
        while (o_l1) begin @(negedge clk); n++; end
        check_eq("R2", "xfer fall to l1 fall", n, GUARD + 6);
        pl1 = o_l1; pp = o_xfer;
        forever begin
            @(negedge clk);
            if (o_l1 && !pl1) since = 0; else since++;
            if (o_xfer && !pp) break;
            pl1 = o_l1; pp = o_xfer;
        end
        check_eq("R2", "l1 rise to xfer rise", since, GUARD);
    endtask

    task automatic t_boundary();
        int n = 0;
        logic pp;
        sync_rise();
        cfg_tp = 8'd16;
        pp = 1'b1;
        forever begin @(negedge clk); n++; if (o_xfer && !pp) break; pp = o_xfer; end
        check_eq("R10", "line in progress keeps old period", n, XTOT + (SEG + CLEAN) * 12);
        n = 0; pp = 1'b1;
        forever begin @(negedge clk); n++; if (o_xfer && !pp) break; pp = o_xfer; end
        check_eq("R10", "next line uses new period", n, XTOT + (SEG + CLEAN) * 16);
        cfg_tp = 8'd12;
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        rst_n = 1'b1;
        check_line("four", 1'b0, 12, 100);
        t_guard();
        t_pixel("tp12", 12);
        cfg_tp = 8'd16;
        t_pixel("tp16", 16);
        check_line("four tp16", 1'b0, 16, 100);
        cfg_tp = 8'd5;            // R5: below floor, raised to 12
        t_pixel("tp floor", 12);
        check_line("floor", 1'b0, 12, 100);
        cfg_tp = 8'd12;
        cfg_two_out = 1'b1;
        check_line("two", 1'b1, 12, 100);
        cfg_exp = 14'd25;         // R8 two-output gate
        check_line("two exp25", 1'b1, 12, 25);
        cfg_two_out = 1'b0;
        cfg_exp = 14'd10;         // R8
        check_line("exp10", 1'b0, 12, 10);
        cfg_exp = 14'd12;         // R8
        check_line("exp12", 1'b0, 12, 12);
        cfg_exp = 14'd3;          // R9 cap
        check_line("exp3", 1'b0, 12, 3);
        cfg_exp = 14'd15;         // R9 full line, gate off
        check_line("exp15", 1'b0, 12, 15);
        cfg_exp = 14'd100;
        check_line("settle", 1'b0, 12, 100);
        t_boundary();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule